// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns a reference clock into the oversampling tick that a UART's serial framing logic consumes. The divisor is supplied as three register values: an upper byte and a lower byte that together form a 16-bit whole-clock count, and a 4-bit remainder expressed in sixteenths of a clock. Over any run of sixteen tick periods the block stretches exactly as many periods by one clock as the remainder says. The mean tick rate is therefore the reference frequency divided by (whole + remainder/16). This gives much finer rate steps than a pure integer divider.

The stretched periods are spread by a phase accumulator rather than grouped together. This keeps the instantaneous timing error below one reference clock. With a 24 MHz reference and 16x sampling, for example, 9600 baud uses whole count 156 with remainder 4. 921600 baud uses whole count 1 with remainder 10, which leaves an error of about 0.16%. 400 baud uses whole count 3750 (upper byte 0x0E, lower byte 0xA6) with remainder 0. A whole count of zero stops the tick. New divisor values are adopted only where one period ends and the next begins.

Top module: `frac_baud_gen`

## Requirements
- R1: The whole count is {div_hi, div_lo} with div_hi in bits 15:8. While running, every interval between consecutive ticks is either the whole count or the whole count plus one reference clock.
- R2: For fixed divisor values, any 16 consecutive tick periods counted from a divisor load add up to exactly 16 x whole + remainder reference clocks.
- R3: Numbering the periods k = 0, 1, 2, ... from a divisor load, period k lasts one extra clock exactly when ((k x remainder) mod 16) + remainder is 16 or more. Period 0 is therefore never stretched.
- R4: With a whole count of 2 or more, tick is high for exactly one reference clock cycle per period.
- R5: When en is first sampled high with a nonzero whole count, the first tick is high in the cycle that follows the whole-count-th rising edge after that sampling edge.
- R6: A whole count of 0 produces no tick for as long as it is in effect.
- R7: When en is sampled low, tick is low in the following cycle. The period count and the remainder phase restart from zero when en returns high.
- R8: A divisor change made during a period does not alter that period. The new values take effect at the next tick boundary, and the remainder phase restarts at period 0 at that boundary.
- R9: During and right after reset, tick is low.
- R10: With whole count 1 and remainder 0, tick stays high on every cycle while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low stops and clears the generator |
| div_hi | input | 8 | Upper byte of the whole-clock divisor |
| div_lo | input | 8 | Lower byte of the whole-clock divisor |
| div_frac | input | 4 | Remainder of the divisor in sixteenths |
| tick | output | 1 | Oversampling tick, one clock per period |

## Verification
On every cycle, the assertions check the following: tick drops after en goes low, a tick never follows a zero whole count, and a tick is a single-cycle pulse when the count is at least 2. They also check that the period counter never runs past the active whole count, that the active divisor stays frozen between boundaries, and that the phase clears after every load. The exact stretching pattern, the sixteen-period totals, the first-tick latency and the point at which a mid-period divisor change lands can only be shown by the bench. It does this by measuring tick intervals under directed rates and randomly drawn divisors.

// File: rtl/frac_baud_pkg.sv
// Package: shared widths and the phase-step helper for the fractional
// baud tick generator. Assumes a remainder width of at most 8 bits.
package frac_baud_pkg;

    localparam int DIV_BYTE_W = 8;   // width of each divisor byte
    localparam int REM_W      = 4;   // remainder width (sixteenths)

    // Sum of phase and remainder, one bit wider; MSB is the stretch flag.
    function automatic logic [REM_W:0] phase_sum(input logic [REM_W-1:0] ph,
                                                  input logic [REM_W-1:0] rem);
        phase_sum = {1'b0, ph} + {1'b0, rem};
    endfunction

endpackage

// File: rtl/fbg_div_shadow.sv
// Module: fbg_div_shadow
// Holds the divisor values that govern the running period. It loads the
// input values on a load strobe and reports whether the inputs differ from
// the held copy. Assumes the caller strobes load only at period boundaries
// or while idle.
module fbg_div_shadow #(
    parameter int WHOLE_W = 16,
    parameter int REM_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WHOLE_W-1:0] in_whole,
    input  logic [REM_W-1:0]   in_rem,
    output logic [WHOLE_W-1:0] act_whole,
    output logic [REM_W-1:0]   act_rem,
    output logic               differs
);

    logic [WHOLE_W-1:0] whole_q;
    logic [REM_W-1:0]   rem_q;

    // Capture the divisor registers when a load is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whole_q <= '0;
            rem_q   <= '0;
        end else if (load) begin
            whole_q <= in_whole;
            rem_q   <= in_rem;
        end
    end

    // Flag any pending divisor change against the active copy.
    always_comb begin
        differs = (in_whole != whole_q) || (in_rem != rem_q);
    end

    assign act_whole = whole_q;
    assign act_rem   = rem_q;

endmodule

// File: rtl/fbg_phase_dither.sv
// Module: fbg_phase_dither
// Remainder phase accumulator. Each completed period adds the remainder
// to the phase modulo 2**REM_W. The current period is stretched by one
// clock when phase + remainder carries out. Assumes clear and advance are
// never used to mean the same boundary twice.
module fbg_phase_dither
    import frac_baud_pkg::*;
#(
    parameter int RW = REM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [RW-1:0] rem,
    output logic          stretch,
    output logic [RW-1:0] phase
);

    logic [RW-1:0] phase_q;
    logic [RW:0]   sum;

    // Form phase plus remainder; its carry selects the long period.
    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, rem};
    end

    // Restart or step the phase at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= sum[RW-1:0];
        end
    end

    assign stretch = sum[RW];
    assign phase   = phase_q;

endmodule

// File: rtl/fbg_period_counter.sv
// Module: fbg_period_counter
// Counts reference clocks inside one tick period and flags the last clock
// of a period of length len. Assumes len >= 1 whenever clear is low.
module fbg_period_counter #(
    parameter int WHOLE_W = 16,
    localparam int LEN_W  = WHOLE_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [LEN_W-1:0]   len,
    output logic [WHOLE_W-1:0] count,
    output logic               last
);

    logic [WHOLE_W-1:0] cnt_q;
    logic [LEN_W-1:0]   cnt_ext;

    // Compare the running count with the final index of the period.
    always_comb begin
        cnt_ext = {1'b0, cnt_q};
        last    = (cnt_ext == len - LEN_W'(1));
    end

    // Advance the count, wrapping to zero after the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + WHOLE_W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen (top)
// Fractional baud-rate tick generator. The period length alternates between
// whole and whole+1 clocks under control of a remainder phase accumulator,
// so that the mean division is whole + rem/2**REM_W. Divisor inputs are
// adopted at start-up and at period boundaries only. Assumes the divisor
// inputs are synchronous to clk.
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int BYTE_W = DIV_BYTE_W,
    parameter int RW     = REM_W,
    localparam int WHOLE_W = 2 * BYTE_W,
    localparam int LEN_W   = WHOLE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [RW-1:0]     div_frac,
    output logic              tick
);

    logic [WHOLE_W-1:0] in_whole;
    logic [WHOLE_W-1:0] act_whole;
    logic [RW-1:0]      act_rem;
    logic               differs;
    logic               stretch;
    logic [RW-1:0]      phase;
    logic [WHOLE_W-1:0] count;
    logic               cnt_last;
    logic [LEN_W-1:0]   len;
    logic               run_q;
    logic               tick_q;
    logic               start;
    logic               boundary;
    logic               load;

    // Join the two divisor bytes into the whole-clock count.
    always_comb begin
        in_whole = {div_hi, div_lo};
    end

    // Decode start-up, period end and divisor load conditions.
    always_comb begin
        start    = en && !run_q;
        boundary = en && run_q && cnt_last;
        load     = start || (boundary && differs);
        len      = {1'b0, act_whole} + LEN_W'(stretch);
    end

    fbg_div_shadow #(
        .WHOLE_W (WHOLE_W),
        .REM_W   (RW)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .in_whole  (in_whole),
        .in_rem    (div_frac),
        .act_whole (act_whole),
        .act_rem   (act_rem),
        .differs   (differs)
    );

    fbg_phase_dither #(
        .RW (RW)
    ) u_dither (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!en || load),
        .advance (boundary && !differs),
        .rem     (act_rem),
        .stretch (stretch),
        .phase   (phase)
    );

    fbg_period_counter #(
        .WHOLE_W (WHOLE_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!en || !run_q),
        .len   (len),
        .count (count),
        .last  (cnt_last)
    );

    // Track whether a nonzero divisor is currently being run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (!en) begin
            run_q <= 1'b0;
        end else if (load) begin
            run_q <= (in_whole != '0);
        end
    end

    // Register the tick so it is a clean pulse at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= boundary;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/frac_baud_gen_chk.sv
// Module: frac_baud_gen_chk
// Property checker attached to frac_baud_gen by bind. It observes the
// ports and the state held by the separate submodules.
module frac_baud_gen_chk #(
    parameter int WHOLE_W = 16,
    parameter int RW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               tick,
    input logic               run_q,
    input logic               boundary,
    input logic               load,
    input logic [WHOLE_W-1:0] act_whole,
    input logic [RW-1:0]      act_rem,
    input logic [RW-1:0]      phase,
    input logic [WHOLE_W-1:0] count
);

    // R7: a low enable silences the tick on the next cycle.
    assert_tick_off_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

    // R4: a tick is a single-cycle pulse when periods are two clocks or more.
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && act_whole >= WHOLE_W'(2)) |=> !tick);

    // R6: a tick only ends a period run with a nonzero whole count.
    assert_zero_whole_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> $past(act_whole) != '0);

    // R1: the in-period count never runs past the whole count.
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> count <= act_whole);

    // R8: the active divisor is frozen away from period boundaries.
    assert_divisor_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && !boundary) |=> ($stable(act_whole) && $stable(act_rem)));

    // R8: the remainder phase restarts after every divisor load.
    assert_phase_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> phase == '0);

endmodule

bind frac_baud_gen frac_baud_gen_chk #(
    .WHOLE_W (WHOLE_W),
    .RW      (RW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .run_q     (run_q),
    .boundary  (boundary),
    .load      (load),
    .act_whole (act_whole),
    .act_rem   (act_rem),
    .phase     (phase),
    .count     (count)
);

// File: tb/test_frac_baud_gen.sv
// Bench for frac_baud_gen: directed rates plus seeded random divisors.
// Tick intervals are measured at falling edges and compared with periods
// computed from the requirements.
module test_frac_baud_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div_hi = '0;
    logic [7:0] div_lo = '0;
    logic [3:0] div_frac = '0;
    logic       tick;

    int total = 0;
    int failed = 0;
    int cycles = 0;
    int seed_val;

    frac_baud_gen i_frac_baud_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .div_hi   (div_hi),
        .div_lo   (div_lo),
        .div_frac (div_frac),
        .tick     (tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++;
            failed++;
            $display("FAIL watchdog R1: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected stretch of period k after a load, from R3.
    function automatic int stretch_of(input int k, input int rem);
        return ((((k * rem) % 16) + rem) >= 16) ? 1 : 0;
    endfunction

    // Count falling edges until tick is seen high (or the limit).
    task automatic wait_tick(input int lim, output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!tick && c < lim);
    endtask

    task automatic set_div(input int whole, input int rem);
        div_hi   = 8'(whole >> 8);
        div_lo   = 8'(whole);
        div_frac = 4'(rem);
    endtask

    // Enable from idle, check latency, then n periods and a 16-period sum.
    task automatic run_case(input int whole, input int rem, input int n);
        int c;
        int sum;
        en = 1'b0;
        repeat (2) @(negedge clk);
        set_div(whole, rem);
        en = 1'b1;
        wait_tick(whole + 4, c);
        chk(c == whole + 1, "R5 first tick latency", c, whole + 1);
        sum = 0;
        for (int k = 1; k <= n; k++) begin
            int exp;
            wait_tick(whole + 4, c);
            exp = whole + stretch_of(k, rem);
            chk(c == exp, "R3 period length", c, exp);
            chk(c == whole || c == whole + 1, "R1 period range", c, whole);
            if (k <= 16) sum += c;
        end
        if (n >= 16)
            chk(sum == 16 * whole + rem, "R2 sixteen-period total", sum, 16 * whole + rem);
        en = 1'b0;
    endtask

    initial begin
        int c;
        int hits;
        seed_val = $urandom(32'd20240611);

        // R9: reset state.
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R9 tick low in reset", int'(tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick == 1'b0, "R9 tick low after reset", int'(tick), 0);

        // Directed rates: 9600, 921600 and 400 baud at a 24 MHz reference.
        run_case(156, 4, 17);
        run_case(1, 10, 17);
        run_case(3750, 0, 3);
        run_case(2, 15, 17);
        run_case(5, 8, 17);

        // R10: whole count 1, no remainder: tick held high.
        en = 1'b0;
        repeat (2) @(negedge clk);
        set_div(1, 0);
        en = 1'b1;
        wait_tick(8, c);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) hits++;
        end
        chk(hits == 20, "R10 continuous tick", hits, 20);
        en = 1'b0;

        // R4: pulse width with whole count 3.
        repeat (2) @(negedge clk);
        set_div(3, 0);
        en = 1'b1;
        wait_tick(8, c);
        @(negedge clk);
        chk(tick == 1'b0, "R4 single-cycle tick", int'(tick), 0);
        en = 1'b0;

        // R6: whole count zero stays silent.
        repeat (2) @(negedge clk);
        set_div(0, 5);
        en = 1'b1;
        hits = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick) hits++;
        end
        chk(hits == 0, "R6 zero divisor no tick", hits, 0);

        // R6: switching a running generator to zero stops it after one boundary.
        en = 1'b0;
        repeat (2) @(negedge clk);
        set_div(6, 0);
        en = 1'b1;
        wait_tick(10, c);
        set_div(0, 0);
        wait_tick(10, c);
        chk(c == 6, "R8 old period completes", c, 6);
        hits = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick) hits++;
        end
        chk(hits == 0, "R6 stopped after change to zero", hits, 0);
        en = 1'b0;

        // R8: mid-period change lands at the next boundary with phase reset.
        repeat (2) @(negedge clk);
        set_div(10, 3);
        en = 1'b1;
        wait_tick(14, c);
        wait_tick(14, c);
        wait_tick(14, c);
        set_div(7, 9);
        wait_tick(14, c);
        chk(c == 10 + stretch_of(3, 3), "R8 running period unchanged", c, 10 + stretch_of(3, 3));
        for (int k = 0; k < 16; k++) begin
            wait_tick(14, c);
            chk(c == 7 + stretch_of(k, 9), "R8 new divisor from phase 0", c, 7 + stretch_of(k, 9));
        end

        // R7: enable low silences the tick and a restart begins at period 0.
        @(negedge clk);
        en = 1'b0;
        hits = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick) hits++;
        end
        chk(hits == 0, "R7 no tick while disabled", hits, 0);
        en = 1'b1;
        wait_tick(14, c);
        chk(c == 8, "R7 restart latency", c, 8);
        wait_tick(14, c);
        chk(c == 7 + stretch_of(1, 9), "R7 phase restarted", c, 7 + stretch_of(1, 9));
        en = 1'b0;

        // Random divisors checked against the requirement model.
        for (int r = 0; r < 8; r++) begin
            int w;
            int f;
            w = 1 + int'($urandom % 60);
            f = int'($urandom % 16);
            run_case(w, f, 17);
        end

        summary();
        $finish;
    end

endmodule